// File: doc/BRIEF.md
# External Interrupt Request Sampler

This block turns a set of active-low external interrupt pins into pending request flags for a small interrupt system. Each pin first passes through a synchronizer. A per-channel trigger-type input then picks how a request is detected. In level mode the flag simply follows the pin, high while the pin is held low. In edge mode a high-to-low transition latches the flag. It then stays set until the interrupt controller acknowledges it or software clears it.

The flags appear on a status output that software can read. Software can also write them through a masked write port. A single request line, the OR of all flags, feeds the priority controller. The controller returns one acknowledge pulse per channel. Every port is a plain control or status signal. Nothing here carries a data stream, so the block has no valid/ready handshake and no back-pressure.

Top module: `ext_irq_sampler`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every pending flag and the request line are 0, and the synchronizers hold the idle high level.
- R2: With a channel's type bit at 0 (level mode), the flag equals the inverse of its pin, delayed by three clock edges: two synchronizer stages and the flag register.
- R3: With the type bit at 1 (edge mode), a high-to-low pin transition sets the flag on the third clock edge after the pin falls. A pin that rises, or that stays low, sets nothing.
- R4: In edge mode a set flag stays set after the pin returns high, until an acknowledge or a software write clears it.
- R5: In edge mode an acknowledge pulse clears the flag on the next edge. If a new falling edge is detected in that same cycle, the flag stays set, because detection wins.
- R6: In level mode the acknowledge has no effect: the flag keeps following the pin.
- R7: A software write with mask bit n high loads data bit n into flag n in edge mode: 1 creates a request and 0 clears one. The write takes priority over an acknowledge and loses to a detected edge. In level mode the write is ignored.
- R8: Channels are independent: activity on one pin, acknowledge or write mask bit never changes another channel's flag.
- R9: The request line is high in the same cycle that any flag is high, and low when none is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_n | input | NCH | Raw active-low interrupt pins, asynchronous |
| trig_edge | input | NCH | Type bit per channel: 0 level, 1 falling edge |
| ack | input | NCH | One-cycle acknowledge per channel from the controller |
| sw_wr_mask | input | NCH | Software write strobe per flag |
| sw_wr_data | input | NCH | Value written to the masked flags |
| pend | output | NCH | Pending flags, readable status |
| irq_req | output | 1 | OR of all pending flags to the priority controller |

## Verification
The bench times each flag change to the exact third edge after a pin moves, so an extra or missing synchronizer stage is caught. It races a fresh falling edge against an acknowledge in the same cycle; a design that lets the acknowledge win would drop an interrupt. It holds a pin low through an acknowledge in edge mode, where a design that detects level instead of transition would set the flag again. It also sends acknowledges and writes to level-mode channels and to the wrong channel, which exposes flags that wrongly latch or channels that leak into each other.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  typedef enum logic {
    TRIG_LEVEL = 1'b0,
    TRIG_EDGE  = 1'b1
  } trig_e;

  // Idle level of an active-low pin.
  localparam logic PIN_IDLE = 1'b1;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int NCH    = 2,
  parameter int STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] raw,
  output logic [NCH-1:0] synced
);
  import ext_irq_pkg::*;

  logic [STAGES-1:0] chain [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[c] <= {STAGES{PIN_IDLE}};
      else        chain[c] <= {chain[c][STAGES-2:0], raw[c]};
    end
    assign synced[c] = chain[c][STAGES-1];

    AST_SYNC_IDLE_AFTER_RESET: assert property (@(posedge clk)
      $rose(rst_n) |-> synced[c] == PIN_IDLE); // R1
  end
endmodule

// File: rtl/irq_channel.sv
module irq_channel (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_s,
  input  logic trig,
  input  logic ack,
  input  logic wr_en,
  input  logic wr_data,
  output logic pend
);
  import ext_irq_pkg::*;

  trig_e mode;
  logic  pin_prev;
  logic  fall;

  assign mode = trig_e'(trig);
  assign fall = pin_prev & ~pin_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_prev <= PIN_IDLE;
    else        pin_prev <= pin_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  pend <= 1'b0;
    else if (mode == TRIG_LEVEL) pend <= ~pin_s;
    else if (fall)               pend <= 1'b1;
    else if (wr_en)              pend <= wr_data;
    else if (ack)                pend <= 1'b0;
  end

  AST_LEVEL_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TRIG_LEVEL) |=> pend == !$past(pin_s)); // R2
  AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TRIG_EDGE && pin_prev && !pin_s) |=> pend); // R3
  AST_EDGE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TRIG_EDGE && pend && !ack && !wr_en) |=> pend); // R4
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TRIG_EDGE && ack && !wr_en && !(pin_prev && !pin_s)) |=> !pend); // R5
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TRIG_EDGE && !pend && !(pin_prev && !pin_s) && !(wr_en && wr_data))
      |=> !pend); // R7
endmodule

// File: rtl/ext_irq_sampler.sv
module ext_irq_sampler #(
  parameter int NCH         = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] pin_n,
  input  logic [NCH-1:0] trig_edge,
  input  logic [NCH-1:0] ack,
  input  logic [NCH-1:0] sw_wr_mask,
  input  logic [NCH-1:0] sw_wr_data,
  output logic [NCH-1:0] pend,
  output logic           irq_req
);
  logic [NCH-1:0] pin_s;

  irq_sync #(.NCH(NCH), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw    (pin_n),
    .synced (pin_s)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    irq_channel u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_s   (pin_s[c]),
      .trig    (trig_edge[c]),
      .ack     (ack[c]),
      .wr_en   (sw_wr_mask[c]),
      .wr_data (sw_wr_data[c]),
      .pend    (pend[c])
    );
  end

  assign irq_req = |pend;

  AST_RESET_CLEAR: assert property (@(posedge clk)
    $rose(rst_n) |-> (pend == '0 && !irq_req)); // R1
endmodule

// File: tb/tb_ext_irq_sampler.sv
module tb_ext_irq_sampler;
  localparam int NCH = 2;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] pin_n = '1;
  logic [NCH-1:0] trig_edge = '0;
  logic [NCH-1:0] ack = '0;
  logic [NCH-1:0] sw_wr_mask = '0;
  logic [NCH-1:0] sw_wr_data = '0;
  logic [NCH-1:0] pend;
  logic           irq_req;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  ext_irq_sampler #(.NCH(NCH), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .pin_n(pin_n), .trig_edge(trig_edge),
    .ack(ack), .sw_wr_mask(sw_wr_mask), .sw_wr_data(sw_wr_data),
    .pend(pend), .irq_req(irq_req)
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic nclk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    nclk(1);
    chk("R1 pend in reset", {2'b0, pend}, 4'h0);
    chk("R9 irq in reset", {3'b0, irq_req}, 4'h0);
    rst_n = 1'b1;
    nclk(1);
    chk("R1 pend after reset", {2'b0, pend}, 4'h0);
  endtask

  task automatic t_level;
    trig_edge = 2'b00;
    pin_n[0] = 1'b0;
    nclk(2);
    chk("R2 level not before 3rd edge", {3'b0, pend[0]}, 4'h0);
    nclk(1);
    chk("R2 level follows low pin", {2'b0, pend}, 4'h1);
    chk("R9 irq high", {3'b0, irq_req}, 4'h1);
    ack[0] = 1'b1;
    nclk(1);
    ack[0] = 1'b0;
    chk("R6 ack ignored in level", {3'b0, pend[0]}, 4'h1);
    sw_wr_mask[0] = 1'b1; sw_wr_data[0] = 1'b0;
    nclk(1);
    sw_wr_mask[0] = 1'b0;
    chk("R7 write 0 ignored in level", {3'b0, pend[0]}, 4'h1);
    pin_n[0] = 1'b1;
    nclk(3);
    chk("R2 level follows high pin", {2'b0, pend}, 4'h0);
    chk("R9 irq low", {3'b0, irq_req}, 4'h0);
    sw_wr_mask[0] = 1'b1; sw_wr_data[0] = 1'b1;
    nclk(1);
    sw_wr_mask[0] = 1'b0;
    chk("R7 write 1 ignored in level", {3'b0, pend[0]}, 4'h0);
  endtask

  task automatic t_edge;
    trig_edge = 2'b10;
    nclk(2);
    pin_n[1] = 1'b0;
    nclk(2);
    chk("R3 edge not before 3rd edge", {3'b0, pend[1]}, 4'h0);
    nclk(1);
    chk("R3 falling edge sets", {2'b0, pend}, 4'h2);
    pin_n[1] = 1'b1;
    nclk(5);
    chk("R4 flag holds after pin high", {2'b0, pend}, 4'h2);
    ack[0] = 1'b1;
    nclk(1);
    ack[0] = 1'b0;
    chk("R8 other ack no effect", {3'b0, pend[1]}, 4'h1);
    ack[1] = 1'b1;
    nclk(1);
    ack[1] = 1'b0;
    chk("R5 ack clears", {2'b0, pend}, 4'h0);
    pin_n[1] = 1'b0;
    nclk(4);
    ack[1] = 1'b1;
    nclk(1);
    ack[1] = 1'b0;
    nclk(4);
    chk("R3 steady low does not re-set", {3'b0, pend[1]}, 4'h0);
    pin_n[1] = 1'b1;
    nclk(5);
    chk("R3 rising edge sets nothing", {3'b0, pend[1]}, 4'h0);
  endtask

  task automatic t_race;
    trig_edge = 2'b10;
    sw_wr_mask = 2'b10; sw_wr_data = 2'b10;
    nclk(1);
    sw_wr_mask = '0; sw_wr_data = '0;
    chk("R7 write 1 sets in edge", {2'b0, pend}, 4'h2);
    pin_n[1] = 1'b0;
    nclk(2);
    ack[1] = 1'b1;
    nclk(1);
    ack[1] = 1'b0;
    chk("R5 edge beats ack", {3'b0, pend[1]}, 4'h1);
    ack[1] = 1'b1; sw_wr_mask[1] = 1'b1; sw_wr_data[1] = 1'b1;
    nclk(1);
    ack[1] = 1'b0; sw_wr_mask[1] = 1'b0; sw_wr_data[1] = 1'b0;
    chk("R7 write beats ack", {3'b0, pend[1]}, 4'h1);
    sw_wr_mask = 2'b01; sw_wr_data = 2'b00;
    nclk(1);
    sw_wr_mask = '0;
    chk("R8 write mask other channel", {3'b0, pend[1]}, 4'h1);
    sw_wr_mask = 2'b10;
    nclk(1);
    sw_wr_mask = '0;
    chk("R7 write 0 clears in edge", {2'b0, pend}, 4'h0);
    pin_n[1] = 1'b1;
    nclk(3);
  endtask

  task automatic t_indep;
    trig_edge = 2'b11;
    nclk(1);
    pin_n[0] = 1'b0;
    nclk(3);
    chk("R8 only ch0 set", {2'b0, pend}, 4'h1);
    chk("R9 irq with ch0", {3'b0, irq_req}, 4'h1);
    pin_n[0] = 1'b1;
    pin_n[1] = 1'b0;
    nclk(3);
    chk("R8 both set", {2'b0, pend}, 4'h3);
    ack = 2'b01;
    nclk(1);
    ack = '0;
    chk("R8 ack ch0 only", {2'b0, pend}, 4'h2);
    ack = 2'b10;
    nclk(1);
    ack = '0;
    chk("R9 irq low when none", {1'b0, irq_req, pend}, 4'h0);
    pin_n[1] = 1'b1;
    nclk(3);
  endtask

  initial begin
    t_reset();
    t_level();
    t_edge();
    t_race();
    t_indep();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule